// File: doc/BRIEF.md
# Bus Hold and Backoff Controller

This controller stands between a core's bus-cycle requester and a local bus that other masters share. It decides, clock by clock, whether the core drives the bus or hands it over. The core presents a request: address, write data, direction, and a beat count. The request stays stable until the controller returns a completion pulse. On the bus side the controller drives address, data and control groups, each with its own output enable, plus a start strobe and a hold acknowledge.

The bus can be released in two ways. A polite hold request (`hold_req`) lets the current cycle run to its last beat. The bus is then floated and `hold_ack` is raised in the same clock. An abort request (`boff_n`, active low) floats the bus in the next clock, even in the middle of a cycle, and never raises `hold_ack`. When the abort is removed, the interrupted cycle is replayed from its first beat. To the core, the replay looks only like extra wait states. Multi-beat cycles are modelled as a beat count that an abort can cut short.

Top module: `bus_yield_ctrl`

## Requirements
- R1: While a cycle is in progress and `boff_n` is high, a high `hold_req` does not float the bus. The enables stay high until the edge at which the final beat is accepted. If `hold_req` is still high at that edge, all enables drop and `hold_ack` rises after it.
- R2: `hold_ack` is high only while `addr_oe`, `ctrl_oe` and `data_oe` are all low. When `hold_req` falls with nothing to replay, `hold_ack` falls and `addr_oe`/`ctrl_oe` rise after the same edge.
- R3: `boff_n` low at a clock edge forces `addr_oe`, `ctrl_oe`, `data_oe` and `hold_ack` low after that edge. This holds in every state, idle included. With nothing to replay, the bus is driven again, idle, after the edge at which `boff_n` is seen high.
- R4: A cycle that was aborted restarts after the abort ends. `bus_start` pulses for one clock, with the original address, direction and write data, and beats are counted again from the first.
- R5: In a clock where `boff_n` is low, a low `rdy_n` or `brdy_n` is ignored. No beat is counted and `core_done` stays low.
- R6: If `hold_req` is high when `boff_n` returns high, the aborted cycle does not restart. `hold_ack` rises instead, and the restart follows the edge at which `hold_req` is seen low.
- R7: While `rst` is high, a high `hold_req` gives `hold_ack` high with all enables low after the edge. A low `hold_req` during reset gives the idle state: `addr_oe` and `ctrl_oe` high, `hold_ack`, `data_oe` and `bus_start` low.
- R8: `core_done` is high, combinationally, only in a clock where a final beat is accepted. A low `rdy_n` ends the cycle on any beat. A low `brdy_n` ends it when the beat index (counted from 0) equals `req_len`. In that clock `core_rdata` equals `bus_rdata`.
- R9: `data_oe` is high only while a write cycle drives the bus. It is low during read cycles, in idle, and while floated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core requests a bus cycle; held until `core_done` |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LW | Number of beats minus one |
| core_done | output | 1 | Completion of the final beat |
| core_rdata | output | DW | Read data of the final beat |
| hold_req | input | 1 | Another master asks for the bus |
| boff_n | input | 1 | Abort and release at once, active low |
| rdy_n | input | 1 | Beat ready that ends the cycle, active low |
| brdy_n | input | 1 | Burst beat ready, active low |
| bus_rdata | input | DW | Read data from the bus |
| bus_addr | output | AW | Address driven on the bus |
| bus_wdata | output | DW | Write data driven on the bus |
| bus_write | output | 1 | Direction driven on the bus |
| bus_start | output | 1 | One-clock strobe at the start of each (re)started cycle |
| addr_oe | output | 1 | Output enable of the address group |
| data_oe | output | 1 | Output enable of the data group |
| ctrl_oe | output | 1 | Output enable of the control group |
| hold_ack | output | 1 | Bus released in answer to `hold_req` |

## Verification
`core_done` and `core_rdata` depend combinationally on the ready and abort inputs. They are due in the same clock the inputs are applied, so the bench checks them shortly after driving inputs and before the edge. The enables, `hold_ack` and `bus_start` come from registers. They change after the single edge that samples the stimulus, so the bench checks them just after that edge and before driving the next vector. Replay is checked by comparing `bus_addr` and `bus_wdata` at each `bus_start` with the original request.

// File: rtl/bus_yield_pkg.sv
package bus_yield_pkg;

    typedef enum logic [2:0] {
        YS_IDLE,
        YS_ACTIVE,
        YS_HOLD_PEND,
        YS_HELD,
        YS_BACKOFF
    } ystate_e;

    function automatic logic in_cycle(ystate_e s);
        return (s == YS_ACTIVE) || (s == YS_HOLD_PEND);
    endfunction

    function automatic logic owns_bus(ystate_e s);
        return (s == YS_IDLE) || in_cycle(s);
    endfunction

endpackage

// File: rtl/bus_yield_fsm.sv
module bus_yield_fsm
    import bus_yield_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hold_req,
    input  logic    boff_n,
    input  logic    req_valid,
    input  logic    last_beat,
    output ystate_e state,
    output logic    launch,
    output logic    restart
);

    ystate_e nxt;
    logic    replay_q;

    always_comb begin
        nxt = state;
        if (!boff_n) begin
            nxt = YS_BACKOFF;
        end else begin
            case (state)
                YS_IDLE: begin
                    if (hold_req)       nxt = YS_HELD;
                    else if (req_valid) nxt = YS_ACTIVE;
                end
                YS_ACTIVE: begin
                    if (last_beat)     nxt = hold_req ? YS_HELD : YS_IDLE;
                    else if (hold_req) nxt = YS_HOLD_PEND;
                end
                YS_HOLD_PEND: begin
                    if (last_beat) nxt = hold_req ? YS_HELD : YS_IDLE;
                end
                YS_HELD: begin
                    if (!hold_req) nxt = replay_q ? YS_ACTIVE : YS_IDLE;
                end
                YS_BACKOFF: begin
                    if (hold_req) nxt = YS_HELD;
                    else          nxt = replay_q ? YS_ACTIVE : YS_IDLE;
                end
                default: nxt = YS_IDLE;
            endcase
        end
    end

    assign launch  = (state == YS_IDLE) && (nxt == YS_ACTIVE);
    assign restart = (nxt == YS_ACTIVE) && !in_cycle(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= hold_req ? YS_HELD : YS_IDLE;
            replay_q <= 1'b0;
        end else begin
            state <= nxt;
            if (!boff_n && in_cycle(state))
                replay_q <= 1'b1;
            else if (restart)
                replay_q <= 1'b0;
        end
    end

endmodule

// File: rtl/bus_yield_cycle.sv
module bus_yield_cycle #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic          restart,
    input  logic          busy,
    input  logic          boff_n,
    input  logic          rdy_n,
    input  logic          brdy_n,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_write,
    input  logic [LW-1:0] req_len,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic          write_q,
    output logic          last_beat,
    output logic          start_q
);

    logic [LW-1:0] len_q;
    logic [LW-1:0] beat_q;
    logic          take;

    assign take      = busy && boff_n && (!rdy_n || !brdy_n);
    assign last_beat = busy && boff_n && (!rdy_n || (!brdy_n && beat_q == len_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            len_q   <= '0;
            beat_q  <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= restart;
            if (launch) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                write_q <= req_write;
                len_q   <= req_len;
            end
            if (restart)
                beat_q <= '0;
            else if (take && !last_beat)
                beat_q <= beat_q + 1'b1;
        end
    end

endmodule

// File: rtl/bus_yield_drive.sv
module bus_yield_drive
    import bus_yield_pkg::*;
(
    input  ystate_e state,
    input  logic    write_q,
    output logic    addr_oe,
    output logic    data_oe,
    output logic    ctrl_oe,
    output logic    hold_ack
);

    assign addr_oe  = owns_bus(state);
    assign ctrl_oe  = owns_bus(state);
    assign data_oe  = in_cycle(state) && write_q;
    assign hold_ack = (state == YS_HELD);

endmodule

// File: rtl/bus_yield_ctrl.sv
module bus_yield_ctrl
    import bus_yield_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_write,
    input  logic [LW-1:0] req_len,
    output logic          core_done,
    output logic [DW-1:0] core_rdata,
    input  logic          hold_req,
    input  logic          boff_n,
    input  logic          rdy_n,
    input  logic          brdy_n,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_write,
    output logic          bus_start,
    output logic          addr_oe,
    output logic          data_oe,
    output logic          ctrl_oe,
    output logic          hold_ack
);

    ystate_e state;
    logic    launch;
    logic    restart;
    logic    last_beat;
    logic    busy;
    logic    write_q;

    assign busy = in_cycle(state);

    bus_yield_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hold_req  (hold_req),
        .boff_n    (boff_n),
        .req_valid (req_valid),
        .last_beat (last_beat),
        .state     (state),
        .launch    (launch),
        .restart   (restart)
    );

    bus_yield_cycle #(.AW(AW), .DW(DW), .LW(LW)) u_cycle (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .restart   (restart),
        .busy      (busy),
        .boff_n    (boff_n),
        .rdy_n     (rdy_n),
        .brdy_n    (brdy_n),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .req_len   (req_len),
        .addr_q    (bus_addr),
        .wdata_q   (bus_wdata),
        .write_q   (write_q),
        .last_beat (last_beat),
        .start_q   (bus_start)
    );

    bus_yield_drive u_drive (
        .state    (state),
        .write_q  (write_q),
        .addr_oe  (addr_oe),
        .data_oe  (data_oe),
        .ctrl_oe  (ctrl_oe),
        .hold_ack (hold_ack)
    );

    assign bus_write  = write_q;
    assign core_done  = last_beat;
    assign core_rdata = bus_rdata;

endmodule

// File: rtl/bus_yield_ctrl_chk.sv
module bus_yield_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic hold_req,
    input logic boff_n,
    input logic rdy_n,
    input logic brdy_n,
    input logic core_done,
    input logic addr_oe,
    input logic data_oe,
    input logic ctrl_oe,
    input logic hold_ack,
    input logic bus_start,
    input logic busy
);

    assert_hold_waits_R1: assert property (@(posedge clk) disable iff (rst)
        (busy && boff_n && !core_done) |=> (ctrl_oe && addr_oe));

    assert_ack_floats_R2: assert property (@(posedge clk) disable iff (rst)
        hold_ack |-> (!addr_oe && !ctrl_oe && !data_oe));

    assert_abort_floats_R3: assert property (@(posedge clk) disable iff (rst)
        !boff_n |=> (!addr_oe && !ctrl_oe && !data_oe && !hold_ack));

    assert_start_drives_R4: assert property (@(posedge clk) disable iff (rst)
        bus_start |-> (ctrl_oe && busy));

    assert_abort_beats_R5: assert property (@(posedge clk) disable iff (rst)
        !boff_n |-> !core_done);

    assert_reset_hold_R7: assert property (@(posedge clk)
        (rst && hold_req) |=> (hold_ack && !ctrl_oe));

    assert_done_ready_R8: assert property (@(posedge clk) disable iff (rst)
        core_done |-> (busy && (!rdy_n || !brdy_n)));

endmodule

bind bus_yield_ctrl bus_yield_ctrl_chk u_chk (.*);

// File: tb/bus_yield_ctrl_tb.sv
`timescale 1ns/1ps
module bus_yield_ctrl_tb;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam int LW = 2;
    localparam int NV = 21;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_write = 1'b0;
    logic [LW-1:0] req_len = '0;
    logic          core_done;
    logic [DW-1:0] core_rdata;
    logic          hold_req = 1'b0;
    logic          boff_n = 1'b1;
    logic          rdy_n = 1'b1;
    logic          brdy_n = 1'b1;
    logic [DW-1:0] bus_rdata = '0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_write;
    logic          bus_start;
    logic          addr_oe;
    logic          data_oe;
    logic          ctrl_oe;
    logic          hold_ack;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bus_yield_ctrl #(.AW(AW), .DW(DW), .LW(LW)) u_dut (.*);

    // {req id[3:0], req_valid, hold_req, boff_n, rdy_n, brdy_n,
    //  exp core_done (before edge), exp oe, exp hold_ack, exp bus_start (after edge)}
    localparam logic [12:0] VEC [NV] = '{
        {4'd4, 5'b10111, 4'b0101},  // R4 new cycle starts
        {4'd8, 5'b10110, 4'b0100},  // R8 first burst beat, not final
        {4'd5, 5'b10010, 4'b0000},  // R5 abort on the last beat
        {4'd6, 5'b11011, 4'b0000},  // R6 hold raised during abort
        {4'd6, 5'b11111, 4'b0010},  // R6 abort gone, hold wins
        {4'd2, 5'b11111, 4'b0010},  // R2 stays held
        {4'd6, 5'b10111, 4'b0101},  // R6 replay after hold release
        {4'd4, 5'b10110, 4'b0100},  // R4 replay beat counted from first
        {4'd1, 5'b11110, 4'b1010},  // R1 final beat, then release for hold
        {4'd2, 5'b00111, 4'b0100},  // R2 hold dropped, bus driven again
        {4'd3, 5'b00011, 4'b0000},  // R3 abort while idle
        {4'd3, 5'b00111, 4'b0100},  // R3 back to idle, nothing replayed
        {4'd8, 5'b10111, 4'b0101},  // R8 next cycle starts
        {4'd1, 5'b11111, 4'b0100},  // R1 hold mid-cycle keeps driving
        {4'd1, 5'b11101, 4'b1010},  // R1 rdy_n ends the cycle, then held
        {4'd2, 5'b00111, 4'b0100},  // R2 release
        {4'd8, 5'b10111, 4'b0101},  // R8 another cycle
        {4'd5, 5'b10001, 4'b0000},  // R5 abort and ready together
        {4'd4, 5'b10111, 4'b0101},  // R4 replay
        {4'd8, 5'b10101, 4'b1100},  // R8 rdy_n completes
        {4'd8, 5'b00111, 4'b0100}   // R8 idle
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        string rq;
        // R7: hold honoured during reset
        rst = 1'b1; hold_req = 1'b1;
        @(posedge clk); #1;
        chk("R7", "hold_ack in reset", hold_ack, 1);
        chk("R7", "ctrl_oe in reset", ctrl_oe, 0);
        @(negedge clk); hold_req = 1'b0;
        @(posedge clk); #1;
        chk("R7", "reset idle ctrl_oe", ctrl_oe, 1);
        chk("R7", "reset idle hold_ack", hold_ack, 0);
        chk("R7", "reset idle bus_start", bus_start, 0);
        chk("R9", "reset idle data_oe", data_oe, 0);
        @(negedge clk); rst = 1'b0;

        // table: read cycle of two beats
        req_addr = 16'h1234; req_write = 1'b0; req_len = 2'd1; bus_rdata = 8'hAA;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rq = $sformatf("R%0d row %0d", VEC[i][12:9], i);
            {req_valid, hold_req, boff_n, rdy_n, brdy_n} = VEC[i][8:4];
            #1;
            chk(rq, "core_done", core_done, VEC[i][3]);
            if (VEC[i][3]) chk(rq, "core_rdata", core_rdata, 8'hAA);
            @(posedge clk); #1;
            chk(rq, "addr_oe", addr_oe, VEC[i][2]);
            chk(rq, "ctrl_oe", ctrl_oe, VEC[i][2]);
            chk(rq, "hold_ack", hold_ack, VEC[i][1]);
            chk(rq, "bus_start", bus_start, VEC[i][0]);
            chk("R9", "data_oe on read", data_oe, 0);
            if (VEC[i][0]) chk("R4", "bus_addr at start", bus_addr, 16'h1234);
        end

        // write cycle, aborted, replayed
        @(negedge clk);
        req_addr = 16'h0BEE; req_wdata = 8'h5A; req_write = 1'b1; req_len = 2'd0;
        req_valid = 1'b1; hold_req = 1'b0; boff_n = 1'b1; rdy_n = 1'b1; brdy_n = 1'b1;
        @(posedge clk); #1;
        chk("R9", "data_oe on write", data_oe, 1);
        chk("R4", "bus_wdata", bus_wdata, 8'h5A);
        chk("R4", "bus_write", bus_write, 1);
        @(negedge clk); boff_n = 1'b0;
        @(posedge clk); #1;
        chk("R3", "data_oe aborted", data_oe, 0);
        chk("R3", "hold_ack aborted", hold_ack, 0);
        @(negedge clk); boff_n = 1'b1;
        @(posedge clk); #1;
        chk("R4", "replay bus_start", bus_start, 1);
        chk("R4", "replay bus_addr", bus_addr, 16'h0BEE);
        chk("R4", "replay bus_wdata", bus_wdata, 8'h5A);
        chk("R9", "replay data_oe", data_oe, 1);
        @(negedge clk); brdy_n = 1'b0; bus_rdata = 8'h3C; #1;
        chk("R8", "single beat done", core_done, 1);
        chk("R8", "done rdata", core_rdata, 8'h3C);
        @(posedge clk); #1;
        chk("R9", "data_oe after write", data_oe, 0);
        @(negedge clk); brdy_n = 1'b1; req_valid = 1'b0;
        @(posedge clk); #1;
        chk("R3", "idle ctrl_oe", ctrl_oe, 1);

        finished = 1;
        summary();
        $finish;
    end

endmodule